// File: doc/BRIEF.md
# Timed Reset Pulse Sequencer

This block drives the active-low reset pin of one attached peripheral. That peripheral does not come out of reset on a single rising edge. It needs two short active pulses, each separated by long released intervals, and then a final settle interval before it may take its first command. The sequencer runs this release pattern from a clock-cycle budget. The budget is computed once, at elaboration, from a clock-frequency parameter and two interval parameters given in nanoseconds.

Three synchronous one-cycle strobes control it. The first holds the pin active indefinitely. The second starts the timed release from a held state. The third pulses the pin active and then runs the timed release. While a release runs, `busy` is high and any strobe is dropped. `ready` goes high when the settle interval ends. `line_active` tells the rest of the chip whether the pin is currently driven active.

Top module: `reset_pulse_seq`

## Requirements
- R1: After the block's own reset (`rst_ni` low), `dev_rst_n` is 0, `line_active` is 1, and `busy` and `ready` are both 0.
- R2: A `cmd_hold` strobe accepted while not busy drives `dev_rst_n` to 0 and keeps it there with `busy` 0 until another command is accepted; it clears `ready` at once.
- R3: A `cmd_release` strobe accepted from the held state produces this pattern: `dev_rst_n` high for L cycles, low for S, high for L, low for S, then high for a settle of L cycles, after which `ready` becomes 1.
- R4: A `cmd_cycle` strobe accepted while not busy (held or ready) first drives `dev_rst_n` low for S cycles and then runs the R3 pattern.
- R5: L = ceil(LONG_NS * CLK_HZ / 1e9) and S = ceil(SHORT_NS * CLK_HZ / 1e9), each at least 1, so no interval is ever shorter than its nanosecond value.
- R6: `busy` is 1 from the cycle after a release or cycle command is accepted until the settle interval ends; in the same cycle that `busy` falls, `ready` rises; both are never high together.
- R7: Strobes that arrive while `busy` is 1 are ignored and do not alter the pattern's timing.
- R8: When several strobes arrive in one cycle, `cmd_cycle` takes precedence over `cmd_hold`, which takes precedence over `cmd_release`.
- R9: A `cmd_release` strobe while `ready` is 1 is ignored: the pin stays high and `ready` stays 1.
- R10: `line_active` is 1 exactly when `dev_rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous block reset, active low |
| cmd_hold | input | 1 | Strobe: hold the peripheral in reset |
| cmd_release | input | 1 | Strobe: run the timed release from the held state |
| cmd_cycle | input | 1 | Strobe: short active pulse, then the timed release |
| dev_rst_n | output | 1 | Active-low reset pin of the peripheral |
| busy | output | 1 | Timed pattern in progress |
| ready | output | 1 | Peripheral may accept its first command |
| line_active | output | 1 | 1 while the reset pin is driven active |

## Verification
The hardest situation to reach from the ports is a strobe that lands on the final cycle of a phase, just before the state changes, because that is where a dropped-strobe filter is most likely to leak. The stimulus measures each phase one cycle at a time. In each phase it picks a random offset, which can be the last cycle, and injects a random non-zero strobe mix there. The bench then requires every phase length to match the computed count exactly. The interval parameters are reduced and deliberately chosen as non-multiples of the clock period, so that rounding up is visible in the lengths.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    PH_HOLD   = 3'd0,
    PH_PRE    = 3'd1,
    PH_REL1   = 3'd2,
    PH_PUL1   = 3'd3,
    PH_REL2   = 3'd4,
    PH_PUL2   = 3'd5,
    PH_SETTLE = 3'd6,
    PH_READY  = 3'd7
  } phase_e;

  // Cycles covering at least ns nanoseconds at hz, rounded up, minimum 1.
  function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                   input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic logic phase_is_timed(input phase_e p);
    return (p != PH_HOLD) && (p != PH_READY);
  endfunction

  function automatic logic phase_line_n(input phase_e p);
    return (p == PH_REL1) || (p == PH_REL2) || (p == PH_SETTLE) || (p == PH_READY);
  endfunction

  function automatic logic phase_is_short(input phase_e p);
    return (p == PH_PRE) || (p == PH_PUL1) || (p == PH_PUL2);
  endfunction

endpackage

// File: rtl/rps_timer.sv
module rps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
  import rps_pkg::*;
#(
  parameter int W         = 8,
  parameter int LONG_CYC  = 100,
  parameter int SHORT_CYC = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         cmd_hold,
  input  logic         cmd_release,
  input  logic         cmd_cycle,
  input  logic         expired,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         step,
  output logic         accept,
  output logic         line_n_q,
  output logic         busy_q,
  output logic         ready_q
);
  localparam logic [W-1:0] LONG_LD  = W'(LONG_CYC - 1);
  localparam logic [W-1:0] SHORT_LD = W'(SHORT_CYC - 1);

  phase_e ph_q, ph_d;
  logic   idle, take_cycle, take_hold, take_release;

  assign idle         = !phase_is_timed(ph_q);
  assign take_cycle   = idle && cmd_cycle;
  assign take_hold    = idle && !cmd_cycle && cmd_hold;
  assign take_release = idle && !cmd_cycle && !cmd_hold && cmd_release && (ph_q == PH_HOLD);
  assign accept       = take_cycle || take_hold || take_release;
  assign step         = phase_is_timed(ph_q) && expired;

  always_comb begin
    ph_d = ph_q;
    if (take_cycle)        ph_d = PH_PRE;
    else if (take_hold)    ph_d = PH_HOLD;
    else if (take_release) ph_d = PH_REL1;
    else if (step) begin
      unique case (ph_q)
        PH_PRE:    ph_d = PH_REL1;
        PH_REL1:   ph_d = PH_PUL1;
        PH_PUL1:   ph_d = PH_REL2;
        PH_REL2:   ph_d = PH_PUL2;
        PH_PUL2:   ph_d = PH_SETTLE;
        PH_SETTLE: ph_d = PH_READY;
        default:   ph_d = ph_q;
      endcase
    end
  end

  assign load     = (take_cycle || take_release || step) && phase_is_timed(ph_d);
  assign load_val = phase_is_short(ph_d) ? SHORT_LD : LONG_LD;

  always_ff @(posedge clk) begin
    if (!rst_ni) begin
      ph_q     <= PH_HOLD;
      line_n_q <= 1'b0;
      busy_q   <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      line_n_q <= phase_line_n(ph_d);
      busy_q   <= phase_is_timed(ph_d);
      ready_q  <= (ph_d == PH_READY);
    end
  end
endmodule

// File: rtl/reset_pulse_seq.sv
module reset_pulse_seq
  import rps_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 200_000_000,
  parameter longint unsigned LONG_NS  = 60_000_000,
  parameter longint unsigned SHORT_NS = 2_000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic cmd_hold,
  input  logic cmd_release,
  input  logic cmd_cycle,
  output logic dev_rst_n,
  output logic busy,
  output logic ready,
  output logic line_active
);
  localparam int LONG_CYC  = int'(ns_to_cycles(LONG_NS, CLK_HZ));
  localparam int SHORT_CYC = int'(ns_to_cycles(SHORT_NS, CLK_HZ));
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int W         = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic         tmr_load, tmr_expired, phase_step, cmd_taken;
  logic [W-1:0] tmr_val;

  rps_timer #(.W(W)) u_timer (
    .clk(clk), .rst_ni(rst_ni), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  rps_fsm #(.W(W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_fsm (
    .clk(clk), .rst_ni(rst_ni),
    .cmd_hold(cmd_hold), .cmd_release(cmd_release), .cmd_cycle(cmd_cycle),
    .expired(tmr_expired), .load(tmr_load), .load_val(tmr_val),
    .step(phase_step), .accept(cmd_taken),
    .line_n_q(dev_rst_n), .busy_q(busy), .ready_q(ready)
  );

  assign line_active = !dev_rst_n;
endmodule

// File: rtl/rps_chk.sv
module rps_chk (
  input logic clk,
  input logic rst_ni,
  input logic dev_rst_n,
  input logic busy,
  input logic ready,
  input logic line_active,
  input logic step,
  input logic accept
);
  // R6
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(busy && ready));

  // R3
  ready_line_high_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ready |-> dev_rst_n);

  // R10
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    line_active == !dev_rst_n);

  // R6
  ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ready) |-> $past(busy));

  // R7
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !accept);

  // R7
  line_only_on_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !step) |=> $stable(dev_rst_n));

  // R2
  hold_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && !ready && !accept) |=> !dev_rst_n);
endmodule

bind reset_pulse_seq rps_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .dev_rst_n(dev_rst_n), .busy(busy),
  .ready(ready), .line_active(line_active), .step(phase_step),
  .accept(cmd_taken)
);

// File: tb/sim_reset_pulse_seq.sv
`timescale 1ns/1ps
module sim_reset_pulse_seq;
  localparam longint unsigned HZ = 200_000_000;
  localparam longint unsigned LNS = 503;
  localparam longint unsigned SNS = 42;

  // R5: own rounding, period 5 ns
  function automatic int exp_cycles(input int ns);
    int c;
    c = ns / 5;
    if (c * 5 < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  logic clk = 0, rst_ni = 0, c_hold = 0, c_rel = 0, c_cyc = 0;
  logic dev_rst_n, busy, ready, line_active;
  int checks = 0, fails = 0;
  int L, S;
  logic inj_en;

  always #2.5 clk = ~clk;

  reset_pulse_seq #(.CLK_HZ(HZ), .LONG_NS(LNS), .SHORT_NS(SNS)) u0 (
    .clk(clk), .rst_ni(rst_ni), .cmd_hold(c_hold), .cmd_release(c_rel),
    .cmd_cycle(c_cyc), .dev_rst_n(dev_rst_n), .busy(busy), .ready(ready),
    .line_active(line_active)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic h, input logic r, input logic c);
    c_hold = h; c_rel = r; c_cyc = c;
    @(negedge clk);
    c_hold = 0; c_rel = 0; c_cyc = 0;
  endtask

  // Measure one phase: count samples at level with busy high (R3, R5, R7, R10)
  task automatic phase(input logic lvl, input int exp, input string req);
    int n = 0;
    int at;
    at = inj_en ? int'($urandom % exp) : -1;
    while (dev_rst_n === lvl && busy === 1'b1 && n < 5000) begin
      if (line_active !== !dev_rst_n) chk(0, "R10", line_active, !dev_rst_n);
      if (ready !== 1'b0) chk(0, "R6", ready, 0);
      if (n == at) begin
        int v = int'($urandom % 7) + 1;
        c_hold = v[0]; c_rel = v[1]; c_cyc = v[2];
      end else begin
        c_hold = 0; c_rel = 0; c_cyc = 0;
      end
      n++;
      @(negedge clk);
    end
    c_hold = 0; c_rel = 0; c_cyc = 0;
    chk(n == exp, req, n, exp);
  endtask

  task automatic run_seq(input logic pre, input string req);
    if (pre) phase(1'b0, S, "R4 pre pulse");
    phase(1'b1, L, req);
    phase(1'b0, S, req);
    phase(1'b1, L, req);
    phase(1'b0, S, req);
    phase(1'b1, L, "R6 settle");
    chk(ready === 1'b1 && busy === 1'b0 && dev_rst_n === 1'b1, "R6 ready end",
        {ready, busy, dev_rst_n}, 3'b101);
  endtask

  task automatic expect_hold(input string req);
    repeat (4) begin
      chk(dev_rst_n === 1'b0 && busy === 1'b0 && ready === 1'b0, req,
          {dev_rst_n, busy, ready}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    L = exp_cycles(int'(LNS));
    S = exp_cycles(int'(SNS));
    inj_en = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(dev_rst_n === 0 && line_active === 1 && busy === 0 && ready === 0, "R1",
        {dev_rst_n, line_active, busy, ready}, 4'b0100);
    rst_ni = 1;
    @(negedge clk);
    chk(dev_rst_n === 0 && busy === 0 && ready === 0, "R1 after", dev_rst_n, 0);
    // R3 plain release from hold
    pulse(0, 1, 0);
    run_seq(0, "R3");
    // R9 release while ready ignored
    pulse(0, 1, 0);
    repeat (3) begin
      chk(ready === 1 && busy === 0 && dev_rst_n === 1, "R9", {ready, busy, dev_rst_n}, 3'b101);
      @(negedge clk);
    end
    // R2 hold from ready
    pulse(1, 0, 0);
    expect_hold("R2");
    // R8 hold beats release
    pulse(1, 1, 0);
    expect_hold("R8 hold over release");
    // R8 cycle beats everything; R7 with injection
    inj_en = 1;
    pulse(1, 1, 1);
    run_seq(1, "R8 cycle wins");
    // R4 cycle from ready
    pulse(0, 0, 1);
    run_seq(1, "R4");
    // random mix
    for (int i = 0; i < 10; i++) begin
      int op = int'($urandom % 4);
      logic was_ready = ready;
      case (op)
        0: begin pulse(1, 0, 0); expect_hold("R2 rand"); end
        1: begin
             pulse(0, 1, 0);
             if (was_ready) chk(ready === 1 && dev_rst_n === 1, "R9 rand", ready, 1);
             else run_seq(0, "R7 rand");
           end
        2: begin pulse(0, 0, 1); run_seq(1, "R4 rand"); end
        default: begin pulse(1, 1, 1); run_seq(1, "R8 rand"); end
      endcase
      @(negedge clk);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule